// File: doc/BRIEF.md
# SD Card SPI-Mode Block Writer

This engine moves one or more data blocks from a byte stream into an SD/MMC card running in SPI mode. A controller pulses `start` together with a block count, a block length and a burst flag. The engine then pulls payload bytes through a ready/valid stream and runs every SPI byte through a request/acknowledge exchange port that sits in front of an SPI master. For each exchange the engine offers one transmit byte and takes back the byte the card returned.

For each block the engine sends a filler byte and a start token, then the payload, then a CRC16 of the payload. It then looks for the card's data-response token and waits until the card stops signalling busy. A burst whose blocks all succeed ends with a stop token and a second busy wait. The engine closes every operation with a one-cycle `done` pulse and a two-bit result code. The CRC is built while the bytes pass, so no block is buffered. The busy-poll limit is a parameter.

Top module: `sdspi_block_writer`

## Requirements
- R1: Each block begins with exchange byte 0xFF and then a start token: 0xFC when `multi` is 1, 0xFE when it is 0. The block's `blk_size` payload bytes follow in stream order.
- R2: Two CRC bytes follow the payload, high byte first. The CRC is CRC16 with polynomial x^16+x^12+x^5+1 and initial value 0, computed over the payload bytes MSB first.
- R3: After the CRC the engine sends 0xFF and reads back at most 8 bytes. The first byte it reads with bit 4 equal to 0 is the response token. If 8 bytes arrive without such a byte, the operation ends with result 2'b01.
- R4: A token whose bits [4:0] equal 0x05 means the block was accepted. Any other token (for example 0x0B or 0x0D) ends the operation at once with result 2'b01: no stop token is sent and no further payload bytes are taken.
- R5: After acceptance the engine polls with 0xFF until it reads 0xFF. The first poll never ends the wait, even when it returns 0xFF. A 0xFF that arrives on the last allowed poll still ends the wait with success.
- R6: If POLL_LIMIT polls pass in a busy wait without an end, the operation ends with result 2'b10 and no further exchange takes place.
- R7: When all blocks of a burst are accepted, the engine sends 0xFF and then 0xFD and runs a busy wait under the rules of R5 and R6. With a block count of zero, a burst sends only this stop sequence, and a single-block request finishes with success and no exchange.
- R8: `done` is a one-cycle pulse. `err` carries 2'b00 for success, 2'b01 for reject and 2'b10 for timeout, and keeps that value from the done pulse until the next start.
- R9: `xfer_req` stays high with `xfer_tx` stable until `xfer_ack`. `in_ready` is high only while a payload byte is due and no exchange is outstanding.
- R10: After reset `done`, `xfer_req` and `in_ready` are 0 and `err` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation; taken only when the engine is idle |
| multi | input | 1 | 1 selects burst mode, 0 selects single-block mode |
| blk_count | input | 16 | Number of blocks to write |
| blk_size | input | 10 | Payload bytes per block, 1 to 512 |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is valid |
| in_ready | output | 1 | Engine takes the payload byte |
| xfer_req | output | 1 | Exchange request toward the SPI master |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Exchange finished; `xfer_rx` is valid |
| xfer_rx | input | 8 | Byte received from the card |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code |

## Verification
Two events can fall on the same poll. On the last poll the limit permits, the busy wait can both reach its limit and see the card's 0xFF that ends busy. The bench provokes this by sending 0xFF first, then exactly POLL_LIMIT-2 busy bytes, then 0xFF, so the release arrives on the final allowed poll. The case passes only if `err` reads 2'b00 and the exchange count matches. A neighbouring case sends busy bytes on all POLL_LIMIT polls and must end in 2'b10 with no stop token.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_FILL, ST_TOKEN, ST_DATA, ST_CRC_HI, ST_CRC_LO, ST_RESP,
      ST_BUSY, ST_STOP_FILL, ST_STOP_TOKEN, ST_STOP_BUSY, ST_FIN
   } sdw_state_e;

   localparam logic [1:0] RES_OK      = 2'b00;
   localparam logic [1:0] RES_REJECT  = 2'b01;
   localparam logic [1:0] RES_TIMEOUT = 2'b10;

   localparam logic [7:0] BYTE_IDLE   = 8'hFF;
   localparam logic [7:0] TOK_ONE     = 8'hFE;
   localparam logic [7:0] TOK_BURST   = 8'hFC;
   localparam logic [7:0] TOK_END     = 8'hFD;
   localparam logic [4:0] CODE_ACCEPT = 5'h05;

   // one byte through the CCITT polynomial, MSB first
   function automatic logic [15:0] crc_next(input logic [15:0] c, input logic [7:0] d,
                                            input logic [15:0] poly);
      logic [15:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ poly;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction
endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16 #(
   parameter logic [15:0] POLY = 16'h1021
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= sdw_pkg::crc_next(crc, din, POLY);
   end
endmodule

// File: rtl/sdw_dnctr.sv
module sdw_dnctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         dec,
   output logic         is_one
);
   logic [W-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= ld_val;
      else if (dec)  cnt <= cnt - W'(1);
   end
   assign is_one = (cnt == W'(1));
endmodule

// File: rtl/sdw_poll_ctr.sv
module sdw_poll_ctr #(
   parameter int LIMIT = 3_000_000,
   localparam int PW   = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic first,
   output logic last
);
   logic [PW-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + PW'(1);
   end
   assign first = (cnt == '0);
   assign last  = (cnt == PW'(LIMIT - 1));
endmodule

// File: rtl/sdspi_block_writer.sv
module sdspi_block_writer
   import sdw_pkg::*;
#(
   parameter int SIZE_W     = 10,
   parameter int CNT_W      = 16,
   parameter int MAX_BLK    = 512,
   parameter int POLL_LIMIT = 3_000_000,
   parameter int RESP_TRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              multi,
   input  logic [CNT_W-1:0]  blk_count,
   input  logic [SIZE_W-1:0] blk_size,
   input  logic [7:0]        in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              xfer_req,
   output logic [7:0]        xfer_tx,
   input  logic              xfer_ack,
   input  logic [7:0]        xfer_rx,
   output logic              done,
   output logic [1:0]        err
);
   localparam int TRY_W = $clog2(RESP_TRIES + 1);

   if (MAX_BLK >= (1 << SIZE_W)) begin : g_bad_size
      $error("SIZE_W too narrow for MAX_BLK");
   end
   if (POLL_LIMIT < 2) begin : g_bad_poll
      $error("POLL_LIMIT must be at least 2");
   end
   if (RESP_TRIES < 1) begin : g_bad_tries
      $error("RESP_TRIES must be at least 1");
   end

   sdw_state_e        state;
   logic              multi_q;
   logic [SIZE_W-1:0] size_q;
   logic [TRY_W-1:0]  tries;
   logic              ack, launch;
   logic [7:0]        tx_next;
   logic [15:0]       crc;
   logic              blk_last, byte_last, poll_first, poll_last;
   logic              idle_go, busy_end;

   assign ack      = xfer_req & xfer_ack;
   assign in_ready = (state == ST_DATA) & ~xfer_req;
   assign done     = (state == ST_FIN);
   assign idle_go  = (state == ST_IDLE) & start;
   assign busy_end = ~poll_first & (xfer_rx == BYTE_IDLE);

   // which byte each state offers, and whether it can go now
   always_comb begin
      tx_next = BYTE_IDLE;
      launch  = 1'b0;
      unique case (state)
         ST_FILL, ST_RESP, ST_BUSY, ST_STOP_FILL, ST_STOP_BUSY: launch = ~xfer_req;
         ST_TOKEN:      begin launch = ~xfer_req; tx_next = multi_q ? TOK_BURST : TOK_ONE; end
         ST_STOP_TOKEN: begin launch = ~xfer_req; tx_next = TOK_END; end
         ST_CRC_HI:     begin launch = ~xfer_req; tx_next = crc[15:8]; end
         ST_CRC_LO:     begin launch = ~xfer_req; tx_next = crc[7:0]; end
         ST_DATA:       begin launch = in_ready & in_valid; tx_next = in_data; end
         default:       launch = 1'b0;
      endcase
   end

   sdw_crc16 u_crc (
      .clk(clk), .rst_n(rst_n),
      .clr(ack && state == ST_TOKEN),
      .en(launch && state == ST_DATA),
      .din(in_data), .crc(crc)
   );

   sdw_dnctr #(.W(CNT_W)) u_blk_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(idle_go), .ld_val(blk_count),
      .dec(ack && state == ST_BUSY && busy_end),
      .is_one(blk_last)
   );

   sdw_dnctr #(.W(SIZE_W)) u_byte_ctr (
      .clk(clk), .rst_n(rst_n),
      .load(ack && state == ST_TOKEN), .ld_val(size_q),
      .dec(ack && state == ST_DATA),
      .is_one(byte_last)
   );

   sdw_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
      .clk(clk), .rst_n(rst_n),
      .clr(ack && (state == ST_RESP || state == ST_STOP_TOKEN)),
      .inc(ack && (state == ST_BUSY || state == ST_STOP_BUSY)),
      .first(poll_first), .last(poll_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         xfer_req <= 1'b0;
         xfer_tx  <= BYTE_IDLE;
         err      <= RES_OK;
         multi_q  <= 1'b0;
         size_q   <= '0;
         tries    <= '0;
      end else begin
         if (launch) begin
            xfer_req <= 1'b1;
            xfer_tx  <= tx_next;
         end else if (ack) begin
            xfer_req <= 1'b0;
         end
         unique case (state)
            ST_IDLE: if (start) begin
               err     <= RES_OK;
               multi_q <= multi;
               size_q  <= blk_size;
               if (blk_count == '0) state <= multi ? ST_STOP_FILL : ST_FIN;
               else                 state <= ST_FILL;
            end
            ST_FILL:       if (ack) state <= ST_TOKEN;
            ST_TOKEN:      if (ack) state <= ST_DATA;
            ST_DATA:       if (ack && byte_last) state <= ST_CRC_HI;
            ST_CRC_HI:     if (ack) state <= ST_CRC_LO;
            ST_CRC_LO:     if (ack) begin state <= ST_RESP; tries <= '0; end
            ST_RESP: if (ack) begin
               if (!xfer_rx[4]) begin
                  if (xfer_rx[4:0] == CODE_ACCEPT) state <= ST_BUSY;
                  else begin err <= RES_REJECT; state <= ST_FIN; end
               end else if (tries == TRY_W'(RESP_TRIES - 1)) begin
                  err <= RES_REJECT; state <= ST_FIN;
               end else begin
                  tries <= tries + TRY_W'(1);
               end
            end
            ST_BUSY, ST_STOP_BUSY: if (ack) begin
               if (busy_end) begin
                  if (state == ST_STOP_BUSY) state <= ST_FIN;
                  else if (!blk_last)        state <= ST_FILL;
                  else                       state <= multi_q ? ST_STOP_FILL : ST_FIN;
               end else if (poll_last) begin
                  err <= RES_TIMEOUT; state <= ST_FIN;
               end
            end
            ST_STOP_FILL:  if (ack) state <= ST_STOP_TOKEN;
            ST_STOP_TOKEN: if (ack) state <= ST_STOP_BUSY;
            ST_FIN:        state <= ST_IDLE;
            default:       state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       done,
   input logic [1:0] err,
   input logic       xfer_req,
   input logic       xfer_ack,
   input logic [7:0] xfer_tx,
   input logic       in_ready
);
   // R8: completion is a single-cycle pulse
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: result code stays put after the pulse
   assert_err_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(err));
   // R8: only the three defined codes are reported
   assert_err_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> err != 2'b11);
   // R9: an open request holds its byte until acknowledged
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));
   // R9: payload is never taken while an exchange is outstanding
   assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !xfer_req);
   // R9: an acknowledged exchange closes its request
   assert_ack_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_ack) |=> !xfer_req);
endmodule

bind sdspi_block_writer sdw_checker u_sdw_checker (
   .clk(clk), .rst_n(rst_n), .done(done), .err(err),
   .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_tx(xfer_tx), .in_ready(in_ready)
);

// File: tb/sdspi_block_writer_tb_top.sv
module sdspi_block_writer_tb_top;
   localparam int LIM   = 20;
   localparam int DEPTH = 2048;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, multi = 1'b0, in_valid = 1'b0, xfer_ack = 1'b0;
   logic [15:0] blk_count = '0;
   logic [9:0]  blk_size = '0;
   logic [7:0]  in_data = '0, xfer_rx = 8'hFF, xfer_tx;
   logic in_ready, xfer_req, done;
   logic [1:0] err;

   always #2 clk = ~clk;

   sdspi_block_writer #(.POLL_LIMIT(LIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .multi(multi),
      .blk_count(blk_count), .blk_size(blk_size),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
      .done(done), .err(err)
   );

   int checks = 0, errors = 0, cycles = 0;
   logic [7:0] exp_tx [DEPTH];
   logic [7:0] rx_s   [DEPTH];
   logic [7:0] dat    [DEPTH];
   int n_x, n_d, idx, dptr, dly;
   bit hs_pend, active, wd;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) wd = 1'b1;
   end

   function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb;
         fb = r[15] ^ d[i];
         r  = r << 1;
         if (fb) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // card model: answers each exchange after a random delay
   always @(negedge clk) begin
      if (xfer_ack) xfer_ack = 1'b0;
      else if (xfer_req && active) begin
         if (dly == 0) begin
            checks++;
            if (idx >= n_x) begin
               errors++;
               $display("FAIL R1 R4 R6 extra exchange %0d actual=%0h expected=none", idx, xfer_tx);
               xfer_rx = 8'hFF;
            end else begin
               if (xfer_tx !== exp_tx[idx]) begin
                  errors++;
                  $display("FAIL R1 R2 R3 R7 exchange %0d actual=%0h expected=%0h", idx, xfer_tx, exp_tx[idx]);
               end
               xfer_rx = rx_s[idx];
            end
            xfer_ack = 1'b1;
            idx++;
            dly = $urandom % 3;
         end else dly--;
      end
   end

   // payload source with random gaps
   always @(negedge clk) begin
      if (hs_pend) dptr++;
      in_valid = active && (dptr < n_d) && ($urandom % 4 != 0);
      in_data  = (dptr < n_d) ? dat[dptr] : 8'h00;
      hs_pend  = in_valid && in_ready;
   end

   task automatic push(input logic [7:0] t, input logic [7:0] r);
      exp_tx[n_x] = t; rx_s[n_x] = r; n_x++;
   endtask

   task automatic add_busy(input int n);
      push(8'hFF, 8'hFF);                       // first poll is ignored
      for (int i = 0; i < n; i++) push(8'hFF, 8'($urandom % 255));
      push(8'hFF, 8'hFF);
   endtask

   task automatic build(input bit m, input int cnt, input int sz, input int pre,
                        input logic [7:0] last_tok, input int busy_n, input bit busy_to,
                        input int stop_n, input bit stop_to);
      bit alive = 1'b1;
      logic [15:0] c;
      logic [7:0] d, tok;
      n_x = 0; n_d = 0;
      for (int b = 0; b < cnt && alive; b++) begin
         push(8'hFF, 8'hFF);
         push(m ? 8'hFC : 8'hFE, 8'hFF);
         c = '0;
         for (int k = 0; k < sz; k++) begin
            d = 8'($urandom);
            dat[n_d] = d; n_d++;
            c = crc_ref(c, d);
            push(d, 8'hFF);
         end
         push(c[15:8], 8'hFF);
         push(c[7:0], 8'hFF);
         tok = (b == cnt - 1) ? last_tok : (8'h05 | (8'($urandom) & 8'hE0));
         if (tok[4]) begin
            for (int i = 0; i < 8; i++) push(8'hFF, 8'hFF);
            alive = 1'b0;
         end else begin
            for (int i = 0; i < pre; i++) push(8'hFF, 8'hFF);
            push(8'hFF, tok);
            if (tok[4:0] != 5'h05) alive = 1'b0;
            else if (busy_to && b == cnt - 1) begin
               for (int i = 0; i < LIM; i++) push(8'hFF, 8'h00);
               alive = 1'b0;
            end else add_busy(busy_n);
         end
      end
      if (alive && m) begin
         push(8'hFF, 8'hFF);
         push(8'hFD, 8'hFF);
         if (stop_to) for (int i = 0; i < LIM; i++) push(8'hFF, 8'h00);
         else add_busy(stop_n);
      end
   endtask

   task automatic run_case(input string tag, input bit m, input int cnt, input int sz,
                           input logic [1:0] exp_err);
      logic [1:0] e0;
      idx = 0; dptr = 0; dly = 0; hs_pend = 1'b0;
      @(negedge clk);
      active = 1'b1;
      start = 1'b1; multi = m; blk_count = 16'(cnt); blk_size = 10'(sz);
      @(negedge clk);
      start = 1'b0;
      while (!done && !wd) @(negedge clk);
      e0 = err;
      check({tag, " result"}, int'(err), int'(exp_err));
      @(negedge clk);
      check("R8 done pulse", int'(done), 0);
      check("R8 err held", int'(err), int'(e0));
      check({tag, " exchange count"}, idx, n_x);
      check({tag, " payload taken R4"}, dptr, n_d);
      active = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5EED));
      active = 1'b0; wd = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 done", int'(done), 0);
      check("R10 xfer_req", int'(xfer_req), 0);
      check("R10 in_ready", int'(in_ready), 0);
      check("R10 err", int'(err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      build(0, 1, 4, 0, 8'h05, 2, 0, 0, 0);           run_case("R1 R2 R5 single", 0, 1, 4, 2'b00);
      build(1, 3, 9, 3, 8'hE5, 1, 0, 2, 0);           run_case("R7 burst", 1, 3, 9, 2'b00);
      build(1, 2, 5, 1, 8'h0B, 1, 0, 0, 0);           run_case("R4 crc reject", 1, 2, 5, 2'b01);
      build(0, 1, 6, 7, 8'h0D, 0, 0, 0, 0);           run_case("R3 R4 write error", 0, 1, 6, 2'b01);
      build(0, 1, 3, 0, 8'hFF, 0, 0, 0, 0);           run_case("R3 no token", 0, 1, 3, 2'b01);
      build(1, 2, 4, 0, 8'h05, 1, 1, 0, 0);           run_case("R6 busy timeout", 1, 2, 4, 2'b10);
      build(0, 1, 2, 0, 8'h05, LIM - 2, 0, 0, 0);     run_case("R5 last poll", 0, 1, 2, 2'b00);
      build(1, 0, 4, 0, 8'h05, 0, 0, 0, 0);           run_case("R7 zero burst", 1, 0, 4, 2'b00);
      build(0, 0, 4, 0, 8'h05, 0, 0, 0, 0);           run_case("R7 zero single", 0, 0, 4, 2'b00);
      build(1, 1, 3, 0, 8'h05, 0, 0, 0, 1);           run_case("R6 stop timeout", 1, 1, 3, 2'b10);
      build(0, 1, 512, 2, 8'h05, 3, 0, 0, 0);         run_case("R1 R2 size 512", 0, 1, 512, 2'b00);
      build(1, 2, 1, 0, 8'h05, 0, 0, 1, 0);           run_case("R1 size 1", 1, 2, 1, 2'b00);
      for (int t = 0; t < 6; t++) begin
         bit m_r = 1'($urandom);
         int c_r = 1 + $urandom % 3;
         int s_r = 1 + $urandom % 40;
         build(m_r, c_r, s_r, $urandom % 8, 8'h05 | (8'($urandom) & 8'hE0),
               $urandom % 6, 0, $urandom % 6, 0);
         run_case("R1 R2 R3 R5 random", m_r, c_r, s_r, 2'b00);
      end

      if (wd) begin
         errors++; checks++;
         $display("FAIL watchdog actual=expired expected=finished");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule